// File: doc/BRIEF.md
# Instruction Fetch and Address Sequencer

This block runs the instruction phase of a small processor whose memory is destructive-read. After a start request it does several steps in a fixed order. It copies the program counter into the memory address register and reads the word at that address. It advances the counter. It captures the word in an instruction register and writes the word back so that memory is restored. It then forms the operand address and returns that address to the memory address register, where the execution cycle picks it up.

Every instruction cycle takes the same six clocks. A one-clock completion pulse comes from a stub that stands in for the execution cycles. The instruction word is 18 bits:
- the address mode field is in bits 17:16;
- bit 15 marks a general-class instruction;
- bits 14:0 carry the address field.

The effective address is held in its own register for one clock before it reaches the memory address register.

Top module: `fetch_addr_seq`

## Requirements
- R1: After reset the block is idle: `mem_addr`, `instr` and `eff_addr` are 0, `pc` equals the `RESET_PC` parameter, and `mem_rd`, `mem_wr` and `done` are low.
- R2: A `start` sampled while idle begins a cycle. One clock later the program counter value is on `mem_addr` with `mem_rd` high for one clock. Only in the clock after that read does `pc` show its old value plus one, modulo 2^15.
- R3: The memory read is synchronous. In the clock after the read, `mem_wr` is high for one clock with `mem_wdata` equal to `mem_rdata` at the same `mem_addr`, which restores the word. The next clock shows that word on `instr`.
- R4: When bit 15 of the instruction is 1 (general class), the effective address is the fetch address itself, whatever the mode field holds.
- R5: For a non-general instruction with mode 00 or 11, the effective address equals bits 14:0.
- R6: With mode 01, the effective address is bits 14:0 plus `index_val`, truncated to 15 bits.
- R7: With mode 10, the effective address is bits 14:0 plus the already incremented `pc`, truncated to 15 bits.
- R8: The effective address appears on `eff_addr` one clock after `instr` is loaded. One clock later it is on `mem_addr`, and it stays there until the next fetch.
- R9: `done` is high for exactly one clock, the sixth clock after `start` was accepted. After that clock the block is idle again.
- R10: A `start` that arrives while a cycle is under way, or during the `done` clock, has no effect. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one instruction cycle |
| index_val | input | 15 | Index register value for mode 01 |
| mem_rdata | input | 18 | Registered read data from memory |
| mem_addr | output | 15 | Memory address register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write-back strobe |
| mem_wdata | output | 18 | Write-back data |
| pc | output | 15 | Program counter |
| instr | output | 18 | Instruction register |
| eff_addr | output | 15 | Effective-address holding register |
| done | output | 1 | Instruction cycle complete |

## Verification
Count clocks from the edge that accepts `start`. The results fall due as follows:
- clock 1: nothing visible yet;
- clock 2: the fetch address and the read strobe;
- clock 3: the incremented counter and the write-back;
- clock 4: the instruction register;
- clock 5: the effective address;
- clock 6: the effective address on `mem_addr` and `done`.

A behavioural model in the bench advances a phase counter on the same edges. At every falling edge it compares all outputs with its own expectations, so a result that comes one clock early or late shows up as a miscompare. The program sits near the top of the address space so that the counter and the address adders wrap. At the end the bench memory is compared with the program to confirm that every destroyed word was restored.

// File: rtl/fetch_addr_seq.sv
module fetch_addr_seq #(
  parameter int AW = 15,
  parameter int DW = 18,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] index_val,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] instr,
  output logic [AW-1:0] eff_addr,
  output logic          done
);
  localparam int MODE_LO = DW - 2;
  localparam int CLS_BIT = DW - 3;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD_ADDR, S_READ, S_DECODE_WB, S_FORM_ADDR, S_LOAD_NEXT, S_EXEC_STUB
  } state_t;

  state_t state;
  logic [AW-1:0] lr, zr;
  logic [DW-1:0] nr;
  logic [1:0] mode;
  logic [AW-1:0] fld;

  assign mode = nr[DW-1:MODE_LO];
  assign fld  = nr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc    <= RESET_PC;
      lr    <= '0;
      nr    <= '0;
      zr    <= '0;
    end else begin
      case (state)
        S_IDLE:      if (start) state <= S_LOAD_ADDR;
        S_LOAD_ADDR: begin lr <= pc; state <= S_READ; end
        S_READ:      begin pc <= pc + 1'b1; state <= S_DECODE_WB; end
        S_DECODE_WB: begin nr <= mem_rdata; state <= S_FORM_ADDR; end
        S_FORM_ADDR: begin
          if (nr[CLS_BIT]) zr <= lr;
          else begin
            case (mode)
              2'b01:   zr <= fld + index_val;
              2'b10:   zr <= fld + pc;
              default: zr <= fld;
            endcase
          end
          state <= S_LOAD_NEXT;
        end
        S_LOAD_NEXT: begin lr <= zr; state <= S_EXEC_STUB; end
        S_EXEC_STUB: state <= S_IDLE;
        default:     state <= S_IDLE;
      endcase
    end
  end

  assign mem_addr  = lr;
  assign mem_rd    = (state == S_READ);
  assign mem_wr    = (state == S_DECODE_WB);
  assign mem_wdata = mem_rdata;
  assign instr     = nr;
  assign eff_addr  = zr;
  assign done      = (state == S_EXEC_STUB);

  p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_wb_follows_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wr && $stable(mem_addr)));
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (pc == AW'($past(pc) + 1'b1)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ea_to_mar_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_addr == eff_addr));
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> !done && !mem_rd);
endmodule

// File: tb/tb_fetch_addr_seq.sv
module tb_fetch_addr_seq;
  localparam int AW = 15;
  localparam int DW = 18;
  localparam logic [AW-1:0] PC0 = 15'h7FFC;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] index_val = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr, pc, eff_addr;
  logic mem_rd, mem_wr, done;
  logic [DW-1:0] mem_wdata, instr;

  fetch_addr_seq #(.AW(AW), .DW(DW), .RESET_PC(PC0)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .index_val(index_val),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .pc(pc), .instr(instr),
    .eff_addr(eff_addr), .done(done));

  always #2 clk = ~clk;

  logic [DW-1:0] pmem [int];
  logic [DW-1:0] bmem [int];
  int vecs = 0, errs = 0;

  function automatic logic [DW-1:0] rd(input logic [DW-1:0] m [int], input int a);
    return m.exists(a) ? m[a] : '0;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= rd(bmem, int'(mem_addr));
      bmem[int'(mem_addr)] = '0;
    end
    if (mem_wr) bmem[int'(mem_addr)] = mem_wdata;
  end

  int ph = 0;
  logic [AW-1:0] eL = '0, epc = PC0, eZ = '0;
  logic [DW-1:0] eN = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      case (ph)
        0: if (start) ph = 1;
        1: begin eL = epc; ph = 2; end
        2: begin epc = epc + 1'b1; ph = 3; end
        3: begin eN = rd(pmem, int'(eL)); ph = 4; end
        4: begin
          if (eN[15]) eZ = eL;
          else if (eN[17:16] == 2'b01) eZ = eN[14:0] + index_val;
          else if (eN[17:16] == 2'b10) eZ = eN[14:0] + epc;
          else eZ = eN[14:0];
          ph = 5;
        end
        5: begin eL = eZ; ph = 6; end
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R8 mem_addr", 32'(mem_addr), 32'(eL));
      chk("R2 mem_rd", 32'(mem_rd), 32'(ph == 2));
      chk("R2 pc", 32'(pc), 32'(epc));
      chk("R3 mem_wr", 32'(mem_wr), 32'(ph == 3));
      if (ph == 3) chk("R3 writeback data", 32'(mem_wdata), 32'(rd(pmem, int'(eL))));
      chk("R3 instr", 32'(instr), 32'(eN));
      chk("R4-R7 eff_addr (R4 R5 R6 R7)", 32'(eff_addr), 32'(eZ));
      chk("R9 done", 32'(done), 32'(ph == 6));
      chk("R10 no rd+wr", 32'(mem_rd && mem_wr), 32'd0);
    end
  end

  function automatic logic [DW-1:0] mk(input logic [1:0] m, input logic c, input logic [14:0] f);
    return {m, c, f};
  endfunction

  task automatic run_one(input logic [AW-1:0] idx);
    @(negedge clk);
    index_val = idx;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    pmem[32'h7FFC] = mk(2'b00, 1'b0, 15'h1234);
    pmem[32'h7FFD] = mk(2'b01, 1'b0, 15'h7FF0);
    pmem[32'h7FFE] = mk(2'b10, 1'b0, 15'h0005);
    pmem[32'h7FFF] = mk(2'b11, 1'b0, 15'h2222);
    pmem[0]        = mk(2'b10, 1'b1, 15'h0abc);
    pmem[1]        = mk(2'b10, 1'b0, 15'h7FFF);
    pmem[2]        = mk(2'b01, 1'b0, 15'h0100);
    pmem[3]        = mk(2'b00, 1'b1, 15'h3333);
    for (int a = 4; a < 12; a++) pmem[a] = mk(2'(a), 1'(a >> 2), 15'(a * 1111));
    foreach (pmem[k]) bmem[k] = pmem[k];

    #5;
    vecs++;
    if (mem_addr !== '0 || pc !== PC0 || mem_rd || mem_wr || done || instr !== '0 || eff_addr !== '0) begin
      errs++;
      $display("FAIL R1 reset state actual pc=%h addr=%h expected pc=%h addr=0", pc, mem_addr, PC0);
    end
    @(negedge clk);
    rst_n = 1;

    run_one(15'h0000);
    run_one(15'h0020);
    run_one(15'h0000);
    run_one(15'h0000);
    run_one(15'h0000);
    run_one(15'h0000);
    run_one(15'h7F00);
    run_one(15'h0000);

    @(negedge clk);
    start = 1;
    repeat (40) @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);

    foreach (pmem[k]) begin
      vecs++;
      if (rd(bmem, k) !== pmem[k]) begin
        errs++;
        $display("FAIL R3 restore at %h actual=%h expected=%h", k, rd(bmem, k), pmem[k]);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule